// File: doc/BRIEF.md
# Round-Robin Codeword Distributor

This block sits between a wide receive datapath and four narrower FEC engines. It accepts a stream of 640-bit words carrying back-to-back 5440-bit codewords. Each whole codeword goes to one of four engine ports, taken in a fixed rotating order. Every engine port has a one-codeword buffer that is written at up to 640 bits per cycle and read out at 160 bits per cycle. Four ports draining in parallel therefore keep up with one full-rate input.

A codeword spans 8.5 input words, so every second codeword boundary falls at bit 320 of an input word. The block works in 320-bit half-words. When a boundary falls mid-word, the lower half closes one engine's codeword and the upper half opens the next engine's codeword in the same cycle.

A start marker on the input sets the codeword alignment. Words that arrive before the first marker are discarded. A later marker that does not fall on the current boundary drops the codeword in progress and restarts alignment on the next engine.

Top module: `cw_rr_distributor`

## Requirements
- R1: While reset is low and after it is released, all engine valid and start outputs are low, the overflow flag is low, and the first accepted codeword goes to engine 0.
- R2: Complete codewords go to engines 0, 1, 2, 3, then 0 again, one whole codeword per engine.
- R3: An engine's first 160-bit word appears in the cycle right after the clock edge that stores the codeword's last half-word. Its start flag is high with that word only, and its valid flag stays high for 34 consecutive cycles.
- R4: The codeword is the concatenation of its 320-bit halves, with the first received half least significant. In each input word the low half [319:0] is received before the high half [639:320]. Output word k carries codeword bits [160k+159:160k].
- R5: When a codeword ends at bit 320 of an input word, bits [639:320] of that word become the first half of the next engine's codeword in the same cycle.
- R6: Input words with valid low are ignored and do not change the data or order of any codeword. They only delay when it completes.
- R7: Before the first word with both valid and start high, valid words are discarded and no engine output is produced.
- R8: Once aligned, a start marker on a word whose low half begins a codeword has no effect. A start marker anywhere else discards the partial codeword, which is never output, and the marked word begins a new codeword on the next engine in order.
- R9: A sticky overflow flag rises when a half-word is written into an engine buffer whose drain has not yet read that position. Under legal gap-free or gapped traffic it stays low.
- R10: Under continuous input, each engine's valid output stays high with no gap from one codeword to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 640 | Input word, low half received first |
| in_valid | input | 1 | Input word is present |
| in_start | input | 1 | A codeword starts at bit 0 of this word |
| eng_data | output | 640 | Four 160-bit engine words, engine n at [160n+159:160n] |
| eng_valid | output | 4 | Per-engine word valid |
| eng_sof | output | 4 | Per-engine first word of codeword |
| ovf_err | output | 1 | Sticky buffer overflow flag |

## Verification
A wrong rotating pointer or half-word counter does not show up as a single bad bit. It surfaces at the ports as a codeword on the wrong engine, or as a start flag one cycle early or late. A wrong drain counter shows as chunks out of order or a valid pulse that is not exactly 34 cycles long. The scoreboard fixes the exact cycle of every expected engine word, so any of these faults is reported at the first affected output cycle, at most about 9 input words after the fault. The split-word and realignment cases are driven on purpose, because an off-by-one half-word error appears only there.

// File: rtl/rrd_pkg.sv
// Shared helpers for the round-robin codeword distributor.
// Assumes lane indices are small unsigned values below the lane count.
package rrd_pkg;

    // Next lane in rotating order, wrapping at n_lanes.
    function automatic int unsigned next_lane(input int unsigned cur, input int unsigned n_lanes);
        return (cur + 1 >= n_lanes) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/rr_splitter.sv
// Codeword alignment and lane selection.
// For each accepted input word it decides which lane and which half-word
// slot receive the low and the high 320-bit halves.
// Assumes HALVES >= 3, so the pointer moves by at most one lane per cycle.
module rr_splitter #(
    parameter int N_LANES = 4,
    parameter int HALVES  = 17,
    localparam int IDX_W  = $clog2(HALVES),
    localparam int LP_W   = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_start,
    output logic [N_LANES-1:0] lo_en,
    output logic [IDX_W-1:0]   lo_idx,
    output logic [N_LANES-1:0] hi_en,
    output logic [IDX_W-1:0]   hi_idx
);
    import rrd_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALVES - 1);

    logic             locked;
    logic [IDX_W-1:0] hc;
    logic [LP_W-1:0]  lp;

    logic             accept, realign, lo_last, hi_last;
    logic [IDX_W-1:0] lo_hc, hi_hc, nx_hc;
    logic [LP_W-1:0]  lo_lp, hi_lp, nx_lp;

    function automatic logic [LP_W-1:0] step(input logic [LP_W-1:0] x);
        return LP_W'(next_lane(int'(x), N_LANES));
    endfunction

    // Slot and lane for both halves of the current word, plus the next state.
    always_comb begin
        accept  = in_valid && (locked || in_start);
        realign = in_valid && in_start && locked && (hc != '0);
        lo_hc   = realign ? '0 : hc;
        lo_lp   = realign ? step(lp) : lp;
        lo_last = (lo_hc == LAST_IDX);
        hi_hc   = lo_last ? '0 : lo_hc + 1'b1;
        hi_lp   = lo_last ? step(lo_lp) : lo_lp;
        hi_last = (hi_hc == LAST_IDX);
        nx_hc   = hi_last ? '0 : hi_hc + 1'b1;
        nx_lp   = hi_last ? step(hi_lp) : hi_lp;
    end

    // One-hot lane enables for each half.
    always_comb begin
        for (int g = 0; g < N_LANES; g++) begin
            lo_en[g] = accept && (lo_lp == LP_W'(g));
            hi_en[g] = accept && (hi_lp == LP_W'(g));
        end
        lo_idx = lo_hc;
        hi_idx = hi_hc;
    end

    // Alignment state: lock flag, half-word counter, lane pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            hc     <= '0;
            lp     <= '0;
        end else if (accept) begin
            locked <= 1'b1;
            hc     <= nx_hc;
            lp     <= nx_lp;
        end
    end

    // R2: the lane pointer holds or advances by exactly one lane.
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (lp == $past(lp) || lp == step($past(lp))));

    // R5: a word that closes a codeword at its midpoint feeds two different lanes.
    a_r5_split_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lo_last) |-> (lo_en != hi_en));

    // R7: nothing is routed before alignment unless this word carries the marker.
    a_r7_no_route: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !in_start) |-> (lo_en == '0 && hi_en == '0));

endmodule

// File: rtl/rr_lane_buf.sv
// One engine port: a codeword buffer of HALVES half-words.
// Up to two half-words are written per cycle. The buffer is drained at
// LANE_W bits per cycle, starting right after the last half is stored.
// It assumes half-word slots arrive in increasing order.
// Slots already read may be overwritten by the next codeword while the
// drain of the current one is still running.
module rr_lane_buf #(
    parameter int HALF_W  = 320,
    parameter int LANE_W  = 160,
    parameter int HALVES  = 17,
    localparam int CPH    = HALF_W / LANE_W,
    localparam int CHUNKS = HALVES * CPH,
    localparam int IDX_W  = $clog2(HALVES),
    localparam int CH_W   = $clog2(CHUNKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_en,
    input  logic [IDX_W-1:0]  wr_lo_idx,
    input  logic [HALF_W-1:0] wr_lo_data,
    input  logic              wr_hi_en,
    input  logic [IDX_W-1:0]  wr_hi_idx,
    input  logic [HALF_W-1:0] wr_hi_data,
    output logic [LANE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              ovf_hit
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALVES - 1);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(CHUNKS - 1);

    logic [HALF_W-1:0] mem [HALVES];
    logic              draining;
    logic [CH_W-1:0]   rc;
    logic              done_wr;

    // Final half of a codeword is being stored this cycle.
    always_comb begin
        done_wr = (wr_lo_en && wr_lo_idx == LAST_IDX) || (wr_hi_en && wr_hi_idx == LAST_IDX);
    end

    // Half-word storage.
    always_ff @(posedge clk) begin
        if (wr_lo_en) mem[wr_lo_idx] <= wr_lo_data;
        if (wr_hi_en) mem[wr_hi_idx] <= wr_hi_data;
    end

    // Drain sequencer: restarts on completion, otherwise counts 34 chunks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            draining <= 1'b0;
            rc       <= '0;
        end else if (done_wr) begin
            draining <= 1'b1;
            rc       <= '0;
        end else if (draining) begin
            if (rc == LAST_CH) draining <= 1'b0;
            rc <= (rc == LAST_CH) ? '0 : rc + 1'b1;
        end
    end

    // Output chunk selection and overflow detection against the read position.
    always_comb begin
        out_data  = mem[IDX_W'(int'(rc) / CPH)][(int'(rc) % CPH) * LANE_W +: LANE_W];
        out_valid = draining;
        out_sof   = draining && (rc == '0);
        ovf_hit   = draining &&
                    ((wr_lo_en && int'(rc) < int'(wr_lo_idx) * CPH + CPH - 1) ||
                     (wr_hi_en && int'(rc) < int'(wr_hi_idx) * CPH + CPH - 1));
    end

    // R3: the first chunk with its start flag follows the completing write.
    a_r3_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        done_wr |=> (out_valid && out_sof));

    // R10: a drain in progress continues without a gap or a stray start flag.
    a_r10_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && rc != LAST_CH && !done_wr) |=> (out_valid && !out_sof));

endmodule

// File: rtl/cw_rr_distributor.sv
// Top level: deals whole codewords from a wide input stream to N_LANES
// engine ports in rotating order, each port with its own codeword buffer.
// Assumes IN_W is split into two halves and each half is a whole number
// of LANE_W chunks.
module cw_rr_distributor #(
    parameter int IN_W    = 640,
    parameter int LANE_W  = 160,
    parameter int CW_BITS = 5440,
    parameter int N_LANES = 4,
    localparam int HALF_W = IN_W / 2,
    localparam int HALVES = CW_BITS / HALF_W,
    localparam int IDX_W  = $clog2(HALVES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IN_W-1:0]           in_data,
    input  logic                      in_valid,
    input  logic                      in_start,
    output logic [N_LANES*LANE_W-1:0] eng_data,
    output logic [N_LANES-1:0]        eng_valid,
    output logic [N_LANES-1:0]        eng_sof,
    output logic                      ovf_err
);
    logic [N_LANES-1:0] lo_en, hi_en, ovf_hit;
    logic [IDX_W-1:0]   lo_idx, hi_idx;

    rr_splitter #(.N_LANES(N_LANES), .HALVES(HALVES)) u_split (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .lo_en(lo_en), .lo_idx(lo_idx), .hi_en(hi_en), .hi_idx(hi_idx)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        rr_lane_buf #(.HALF_W(HALF_W), .LANE_W(LANE_W), .HALVES(HALVES)) u_buf (
            .clk(clk), .rst_n(rst_n),
            .wr_lo_en(lo_en[g]), .wr_lo_idx(lo_idx), .wr_lo_data(in_data[HALF_W-1:0]),
            .wr_hi_en(hi_en[g]), .wr_hi_idx(hi_idx), .wr_hi_data(in_data[IN_W-1:HALF_W]),
            .out_data(eng_data[g*LANE_W +: LANE_W]), .out_valid(eng_valid[g]),
            .out_sof(eng_sof[g]), .ovf_hit(ovf_hit[g])
        );
    end

    // Sticky overflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovf_err <= 1'b0;
        else if (|ovf_hit)   ovf_err <= 1'b1;
    end

    // R9: once raised, the overflow flag stays up until reset.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_err) |-> ovf_err);

    // R1: no engine output during the first cycle after reset.
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (eng_valid == '0 && !ovf_err));

endmodule

// File: tb/cw_rr_distributor_tb.sv
`timescale 1ns/1ps
module cw_rr_distributor_tb;
    localparam int NL = 4;
    localparam int HV = 17;
    localparam int CH = 34;

    typedef struct {
        logic [159:0] d;
        bit           sof;
        int           cyc;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [639:0] in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_start = 1'b0;
    logic [639:0] eng_data;
    logic [3:0]   eng_valid, eng_sof;
    logic         ovf_err;

    cw_rr_distributor u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_start(in_start), .eng_data(eng_data), .eng_valid(eng_valid),
        .eng_sof(eng_sof), .ovf_err(ovf_err)
    );

    always #2 clk = ~clk;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    mon_en = 1'b1;
    string tag = "R1";
    exp_t  sb [NL][$];
    int    exp_order[$];
    int    obs_order[$];

    // Reference state built from the requirements.
    bit           m_locked = 1'b0;
    int           m_hc = 0;
    int           m_lp = 0;
    logic [319:0] m_cw [HV];
    int           seq = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [159:0] act, input logic [159:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [639:0] mk(input int n);
        logic [639:0] w;
        for (int i = 0; i < 20; i++)
            w[i*32 +: 32] = (32'(n) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
        return w;
    endfunction

    task automatic put_half(input logic [319:0] h, input int cap);
        m_cw[m_hc] = h;
        if (m_hc == HV - 1) begin
            for (int j = 0; j < CH; j++) begin
                exp_t e;
                e.d   = m_cw[j/2][(j%2)*160 +: 160];
                e.sof = (j == 0);
                e.cyc = cap + j;
                sb[m_lp].push_back(e);
            end
            exp_order.push_back(m_lp);
            m_hc = 0;
            m_lp = (m_lp + 1) % NL;
        end else begin
            m_hc++;
        end
    endtask

    // Driver: presents one word and records what it must produce.
    task automatic send(input bit v, input bit s);
        int cap;
        logic [639:0] d;
        d = mk(seq);
        seq++;
        @(negedge clk);
        in_data = d; in_valid = v; in_start = s;
        cap = cyc + 1;
        if (v) begin
            if (s) begin
                if (!m_locked) begin m_locked = 1'b1; m_hc = 0; end
                else if (m_hc != 0) begin m_hc = 0; m_lp = (m_lp + 1) % NL; end
            end
            if (m_locked) begin
                put_half(d[319:0], cap);
                put_half(d[639:320], cap);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_start = 1'b0;
        end
    endtask

    // Monitor: compares each engine port against its expected queue.
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            for (int l = 0; l < NL; l++) begin
                if (eng_valid[l]) begin
                    if (sb[l].size() == 0 || sb[l][0].cyc != cyc) begin
                        check(1'b0, tag, $sformatf("lane %0d unexpected valid", l),
                              eng_data[l*160 +: 160], '0);
                    end else begin
                        exp_t e;
                        e = sb[l].pop_front();
                        if (eng_sof[l]) obs_order.push_back(l);
                        check(eng_data[l*160 +: 160] == e.d && eng_sof[l] == e.sof, tag,
                              $sformatf("lane %0d word (sof %0d vs %0d)", l, eng_sof[l], e.sof),
                              eng_data[l*160 +: 160], e.d);
                    end
                end else if (sb[l].size() != 0 && sb[l][0].cyc == cyc) begin
                    void'(sb[l].pop_front());
                    check(1'b0, tag, $sformatf("lane %0d missing word", l), '0, 160'd1);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        idle(4);
        check(eng_valid == '0 && eng_sof == '0 && !ovf_err, "R1", "outputs in reset",
              {155'd0, eng_valid, ovf_err}, '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(eng_valid == '0 && !ovf_err, "R1", "outputs after reset",
              {155'd0, eng_valid, ovf_err}, '0);

        // R7: words before the first marker are discarded
        tag = "R7";
        for (int i = 0; i < 5; i++) send(1'b1, 1'b0);
        idle(12);
        check(eng_valid == '0, "R7", "no output before alignment", {156'd0, eng_valid}, '0);

        // R1 R2 R3 R4 R5 R10: eight codewords back to back, first to engine 0
        tag = "R1/R2/R3/R4/R5/R10";
        send(1'b1, 1'b1);
        for (int i = 1; i < 68; i++) send(1'b1, 1'b0);
        // R8: marker on an aligned boundary changes nothing
        tag = "R8";
        send(1'b1, 1'b1);
        for (int i = 0; i < 16; i++) send(1'b1, 1'b0);

        // R6: gaps between words
        tag = "R6";
        for (int i = 0; i < 30; i++) begin
            send(1'b1, 1'b0);
            if (i % 3 != 2) idle(1 + (i % 2));
        end
        idle(80);

        // R8: marker mid-codeword drops the partial and moves to the next engine
        tag = "R8";
        if (m_hc == 0) send(1'b1, 1'b0);
        send(1'b1, 1'b0);
        send(1'b1, 1'b1);
        for (int i = 0; i < 25; i++) send(1'b1, 1'b0);
        idle(80);

        for (int l = 0; l < NL; l++)
            check(sb[l].size() == 0, "R3", $sformatf("lane %0d queue drained", l),
                  160'(sb[l].size()), '0);
        check(exp_order.size() == obs_order.size(), "R2", "codeword count",
              160'(obs_order.size()), 160'(exp_order.size()));
        for (int i = 0; i < exp_order.size() && i < obs_order.size(); i++)
            check(exp_order[i] == obs_order[i], "R2", $sformatf("engine of codeword %0d", i),
                  160'(obs_order[i]), 160'(exp_order[i]));
        check(exp_order.size() > 0 && exp_order[0] == 0, "R1", "first engine",
              160'(obs_order.size() > 0 ? obs_order[0] : 99), '0);
        check(!ovf_err, "R9", "no overflow on legal traffic", {159'd0, ovf_err}, '0);

        // R9: rapid realignment returns to a draining engine
        tag = "R9";
        mon_en = 1'b0;
        if (m_hc != 0) send(1'b1, 1'b1);
        for (int i = 0; i < 9; i++) send(1'b1, i == 0 && m_hc != 0);
        send(1'b1, 1'b1);
        send(1'b1, 1'b1);
        send(1'b1, 1'b1);
        send(1'b1, 1'b0);
        send(1'b1, 1'b0);
        idle(3);
        check(ovf_err, "R9", "overflow raised", {159'd0, ovf_err}, 160'd1);
        idle(60);
        check(ovf_err, "R9", "overflow sticky", {159'd0, ovf_err}, 160'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule